// File: doc/BRIEF.md
# SMBus Block Data Buffer

This block sits between a host register port and an SMBus transaction engine and holds the payload of one block transfer. The host reaches the storage through a single block-data register. An internal index moves forward by one on every access to that register. Before a block write the host loads the whole payload this way. After a block read it drains the payload the same way. Reading the control register sets the index back to the first entry.

The engine has its own sequential port into the same storage, with a separate index that it rewinds at the start of each transfer. A count register holds the block length, and either side may write it. Two bits of an auxiliary register are read back by software. Bit 1 turns buffering on and bit 0 requests packet-error checking from the engine. When buffering is off, the block-data register is a single holding byte shared by both sides.

Top module: `smbus_blk_buf`

## Requirements
- R1: After reset, both indices are 0, all storage and the holding byte are 0, and the control, count and auxiliary registers are 0. buf_en_o and pec_en_o are low.
- R2: host_addr_i selects a register: 0 control, 1 count, 2 block data, 3 auxiliary. In the auxiliary register, bit 1 drives buf_en_o and bit 0 drives pec_en_o. A read returns those two bits, with bits 7:2 reading as 0.
- R3: When buf_en_o is high, a host write to the block-data register stores the byte at the host index and then advances the index.
- R4: When buf_en_o is high, a host read of the block-data register returns the byte at the host index and then advances the index.
- R5: A host read of the control register returns the byte last written there and resets the host index to 0.
- R6: The host index and the engine index each saturate at DEPTH-1 (31). Accesses beyond the end stay on the last entry and do not wrap.
- R7: When buf_en_o is low, host and engine block accesses use one holding byte and neither index moves. Buffer contents are left unchanged.
- R8: The count register holds the block length. The host writes it at address 1, and eng_cnt_we_i loads eng_cnt_i with priority over a host write in the same cycle. cnt_ok_o is high exactly when the count is in the range 1 to DEPTH.
- R9: eng_start_i resets the engine index to 0. eng_wr_i stores eng_wdata_i at the engine index and advances it. eng_rdata_o shows the byte at the engine index, and eng_rd_i advances the index. If both sides store in the same cycle, the engine byte is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host register write strobe |
| host_rd_i | input | 1 | Host register read strobe |
| host_addr_i | input | 2 | Host register select |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for the selected register |
| eng_start_i | input | 1 | Rewind engine index |
| eng_wr_i | input | 1 | Engine store strobe |
| eng_rd_i | input | 1 | Engine consume strobe |
| eng_wdata_i | input | 8 | Engine store data |
| eng_rdata_o | output | 8 | Byte at engine index or holding byte |
| eng_cnt_we_i | input | 1 | Engine count load strobe |
| eng_cnt_i | input | 8 | Engine count value |
| cnt_o | output | 8 | Current block count |
| cnt_ok_o | output | 1 | Count lies in 1..DEPTH |
| buf_en_o | output | 1 | Buffered mode enabled |
| pec_en_o | output | 1 | Packet-error check requested |

## Verification
The hardest case to reach from the ports is the last entry of storage. To show that the index saturates and does not wrap, the stimulus writes DEPTH+1 bytes with distinct values and then reads DEPTH+1 bytes back. The final entry must hold the overflowing byte, and the extra read must repeat it. The disabled-mode case is also subtle, because the proof has to come after buffering is turned back on: a rewind followed by a read must show the buffer contents unchanged. Same-cycle collisions between engine and host stores are driven together in a single cycle and then read back through the host port.

// File: rtl/smbus_blk_pkg.sv
package smbus_blk_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_BLK  = 2'd2,
    REG_AUX  = 2'd3
  } reg_sel_e;

  localparam int AUX_PEC_BIT = 0;
  localparam int AUX_BUF_BIT = 1;
  localparam int AUX_W       = 2;
endpackage

// File: rtl/smbus_blk_idx.sv
module smbus_blk_idx #(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          idx_q <= '0;
    else if (clr_i)                       idx_q <= '0;
    else if (inc_i && idx_q != IDX_MAX)   idx_q <= idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> idx_q == '0);
  a_r6_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && idx_q == IDX_MAX) |=> idx_q == IDX_MAX);
  a_r3_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && idx_q != IDX_MAX) |=> idx_q == $past(idx_q) + 1'b1);
endmodule

// File: rtl/smbus_blk_mem.sv
module smbus_blk_mem #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] raddr_a_i,
  output logic [DW-1:0]    rdata_a_o,
  input  logic [IDX_W-1:0] raddr_b_i,
  output logic [DW-1:0]    rdata_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

  a_r3_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/smbus_blk_buf.sv
module smbus_blk_buf
  import smbus_blk_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_wr_i,
  input  logic          host_rd_i,
  input  logic [1:0]    host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          eng_start_i,
  input  logic          eng_wr_i,
  input  logic          eng_rd_i,
  input  logic [DW-1:0] eng_wdata_i,
  output logic [DW-1:0] eng_rdata_o,
  input  logic          eng_cnt_we_i,
  input  logic [DW-1:0] eng_cnt_i,
  output logic [DW-1:0] cnt_o,
  output logic          cnt_ok_o,
  output logic          buf_en_o,
  output logic          pec_en_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [DW-1:0] MAX_CNT = DW'(DEPTH);

  reg_sel_e         sel;
  logic             host_blk_wr, host_blk_rd, ctrl_rd, buf_en;
  logic [IDX_W-1:0] host_idx, eng_idx, waddr;
  logic [DW-1:0]    wdata, mem_a, mem_b;
  logic [DW-1:0]    ctrl_q, cnt_q, hold_q;
  logic [AUX_W-1:0] aux_q;

  assign sel         = reg_sel_e'(host_addr_i);
  assign host_blk_wr = host_wr_i && sel == REG_BLK;
  assign host_blk_rd = host_rd_i && sel == REG_BLK;
  assign ctrl_rd     = host_rd_i && sel == REG_CTRL;
  assign buf_en      = aux_q[AUX_BUF_BIT];

  smbus_blk_idx #(.DEPTH(DEPTH)) u_host_idx (
    .clk_i, .rst_ni,
    .clr_i (ctrl_rd),
    .inc_i (buf_en && (host_blk_wr || host_blk_rd)),
    .idx_o (host_idx)
  );

  smbus_blk_idx #(.DEPTH(DEPTH)) u_eng_idx (
    .clk_i, .rst_ni,
    .clr_i (eng_start_i),
    .inc_i (buf_en && (eng_wr_i || eng_rd_i)),
    .idx_o (eng_idx)
  );

  // engine store wins a same-cycle collision
  assign waddr = eng_wr_i ? eng_idx : host_idx;
  assign wdata = eng_wr_i ? eng_wdata_i : host_wdata_i;

  smbus_blk_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i, .rst_ni,
    .we_i      (buf_en && (eng_wr_i || host_blk_wr)),
    .waddr_i   (waddr),
    .wdata_i   (wdata),
    .raddr_a_i (host_idx),
    .rdata_a_o (mem_a),
    .raddr_b_i (eng_idx),
    .rdata_b_o (mem_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
      aux_q  <= '0;
    end else begin
      if (host_wr_i && sel == REG_CTRL) ctrl_q <= host_wdata_i;
      if (host_wr_i && sel == REG_AUX)  aux_q  <= host_wdata_i[AUX_W-1:0];
      if (eng_cnt_we_i)                 cnt_q  <= eng_cnt_i;
      else if (host_wr_i && sel == REG_CNT) cnt_q <= host_wdata_i;
      if (!buf_en) begin
        if (eng_wr_i)         hold_q <= eng_wdata_i;
        else if (host_blk_wr) hold_q <= host_wdata_i;
      end
    end
  end

  always_comb begin
    unique case (sel)
      REG_CTRL: host_rdata_o = ctrl_q;
      REG_CNT:  host_rdata_o = cnt_q;
      REG_BLK:  host_rdata_o = buf_en ? mem_a : hold_q;
      default:  host_rdata_o = {{(DW-AUX_W){1'b0}}, aux_q};
    endcase
  end

  assign eng_rdata_o = buf_en ? mem_b : hold_q;
  assign cnt_o       = cnt_q;
  assign cnt_ok_o    = (cnt_q != '0) && (cnt_q <= MAX_CNT);
  assign buf_en_o    = buf_en;
  assign pec_en_o    = aux_q[AUX_PEC_BIT];

  a_r7_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!buf_en && !ctrl_rd && (host_blk_wr || host_blk_rd)) |=> $stable(host_idx));
  a_r8_eng_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_cnt_we_i |=> cnt_o == $past(eng_cnt_i));
  a_r2_aux_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && sel == REG_AUX) |=> buf_en_o == $past(host_wdata_i[AUX_BUF_BIT]));
endmodule

// File: tb/smbus_blk_buf_bench.sv
module smbus_blk_buf_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 0, host_rd = 0, eng_start = 0, eng_wr = 0, eng_rd = 0, eng_cnt_we = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0, eng_wdata = 0, eng_cnt = 0;
  logic [7:0] host_rdata, eng_rdata, cnt;
  logic       cnt_ok, buf_en, pec_en;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  smbus_blk_buf u_smbus_blk_buf (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(host_wr), .host_rd_i(host_rd), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .eng_start_i(eng_start), .eng_wr_i(eng_wr), .eng_rd_i(eng_rd),
    .eng_wdata_i(eng_wdata), .eng_rdata_o(eng_rdata),
    .eng_cnt_we_i(eng_cnt_we), .eng_cnt_i(eng_cnt),
    .cnt_o(cnt), .cnt_ok_o(cnt_ok), .buf_en_o(buf_en), .pec_en_o(pec_en)
  );

  typedef struct packed {
    logic       rd;
    logic [1:0] addr;
    logic [7:0] data;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd3, 8'h03, 4'd2}, '{1'b1, 2'd3, 8'h03, 4'd2},
    '{1'b0, 2'd3, 8'hFE, 4'd2}, '{1'b1, 2'd3, 8'h02, 4'd2},
    '{1'b0, 2'd3, 8'h02, 4'd2},
    '{1'b0, 2'd1, 8'h04, 4'd8}, '{1'b1, 2'd1, 8'h04, 4'd8},
    '{1'b1, 2'd0, 8'h00, 4'd5},
    '{1'b0, 2'd2, 8'h11, 4'd3}, '{1'b0, 2'd2, 8'h22, 4'd3},
    '{1'b0, 2'd2, 8'h33, 4'd3}, '{1'b0, 2'd2, 8'h44, 4'd3},
    '{1'b1, 2'd0, 8'h00, 4'd5},
    '{1'b1, 2'd2, 8'h11, 4'd4}, '{1'b1, 2'd2, 8'h22, 4'd4},
    '{1'b1, 2'd2, 8'h33, 4'd4}, '{1'b1, 2'd2, 8'h44, 4'd4},
    '{1'b0, 2'd0, 8'h5A, 4'd5}, '{1'b1, 2'd0, 8'h5A, 4'd5},
    '{1'b1, 2'd2, 8'h11, 4'd5}, '{1'b1, 2'd2, 8'h22, 4'd4}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    host_wr = 0; host_rd = 0; eng_start = 0; eng_wr = 0; eng_rd = 0; eng_cnt_we = 0;
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    host_wr = 1; host_addr = a; host_wdata = d; tick();
  endtask

  task automatic hrd(input logic [1:0] a, input logic [7:0] e, input string req);
    host_rd = 1; host_addr = a; #1; chk(req, host_rdata, e); tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #5 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    host_addr = 2'd3; #0.5 chk("R1", host_rdata, 8'h00);
    host_addr = 2'd1; #0.5 chk("R1", host_rdata, 8'h00);
    host_addr = 2'd0; #0.5 chk("R1", host_rdata, 8'h00);
    host_addr = 2'd2; #0.5 chk("R1", host_rdata, 8'h00);
    chk("R1", {6'b0, buf_en, pec_en}, 8'h00);
    chk("R1", eng_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      if (VECS[i].rd) hrd(VECS[i].addr, VECS[i].data, tag);
      else            hwr(VECS[i].addr, VECS[i].data);
    end
    chk("R2", {6'b0, buf_en, pec_en}, 8'h02);

    // R6 saturation: 33 writes, last lands on entry 31
    hrd(2'd0, 8'h5A, "R5");
    for (int i = 0; i <= 32; i++) hwr(2'd2, 8'h40 + 8'(i));
    hrd(2'd0, 8'h5A, "R5");
    for (int i = 0; i < 31; i++) begin
      if (i == 0 || i == 30) hrd(2'd2, 8'h40 + 8'(i), "R6");
      else                   hrd(2'd2, 8'h40 + 8'(i), "R4");
    end
    hrd(2'd2, 8'h60, "R6");
    hrd(2'd2, 8'h60, "R6");

    // R7 disabled mode: holding byte
    hwr(2'd3, 8'h00);
    hrd(2'd0, 8'h5A, "R5");
    hwr(2'd2, 8'hA5);
    hrd(2'd2, 8'hA5, "R7");
    hrd(2'd2, 8'hA5, "R7");
    chk("R7", eng_rdata, 8'hA5);
    hwr(2'd3, 8'h02);
    hrd(2'd2, 8'h40, "R7");
    hrd(2'd2, 8'h41, "R7");

    // R8 count register and range flag
    hwr(2'd1, 8'd0);  chk("R8", {7'b0, cnt_ok}, 8'd0);
    hwr(2'd1, 8'd1);  chk("R8", {7'b0, cnt_ok}, 8'd1);
    hwr(2'd1, 8'd32); chk("R8", {7'b0, cnt_ok}, 8'd1);
    hwr(2'd1, 8'd33); chk("R8", {7'b0, cnt_ok}, 8'd0);
    eng_cnt_we = 1; eng_cnt = 8'h07; hwr(2'd1, 8'h09);
    chk("R8", cnt, 8'h07);
    hrd(2'd1, 8'h07, "R8");

    // R9 engine port
    eng_start = 1; tick();
    eng_wr = 1; eng_wdata = 8'hB0; tick();
    eng_wr = 1; eng_wdata = 8'hB1; tick();
    eng_wr = 1; eng_wdata = 8'hB2; tick();
    eng_start = 1; tick();
    chk("R9", eng_rdata, 8'hB0);
    eng_rd = 1; tick();
    chk("R9", eng_rdata, 8'hB1);
    hrd(2'd0, 8'h5A, "R5");
    hrd(2'd2, 8'hB0, "R9");
    hrd(2'd2, 8'hB1, "R9");
    hrd(2'd2, 8'hB2, "R9");
    eng_start = 1; tick();
    hrd(2'd0, 8'h5A, "R5");
    eng_wr = 1; eng_wdata = 8'hC0; hwr(2'd2, 8'hD0);
    hrd(2'd0, 8'h5A, "R5");
    hrd(2'd2, 8'hC0, "R9");

    finish_run();
  end
endmodule